// File: doc/BRIEF.md
# Circular Command Queue Reader

The block consumes fixed-size commands from a ring buffer in memory. Software writes commands into the ring first and then moves a write offset forward. The block fetches entries one at a time from the read offset, and it advances that offset after each command decodes cleanly. The read offset wraps at the end of the ring. The queue has drained when the two offsets are equal and no fetch is outstanding.

A fault from the command decoder stops the queue. The block raises a stalled flag and leaves the read offset on the faulting entry. When error reporting is enabled, it also captures a syndrome record. The stall happens whether or not reporting is enabled. To recover, software repairs the entry, or overwrites it with a no-op synchronisation command, and then pulses retry. The block resumes by fetching that same entry again. A write offset that points past the end of the ring also stalls the queue, and in that case no fetch is made.

Each entry is 32 bytes. The ring size is 2^`cfgSizeLog2` entries, and both offsets count entries rather than bytes.

Top module: `cmdq_reader`

## Requirements
- R1: After reset, the read offset is 0, stalled is 0, idle is 1, rdReq is 0 and errValid is 0.
- R2: When the write offset differs from the read offset, the block fetches the entries in ring order. It requests one entry per rdReq pulse, at address cfgBase + offset*32, and never has more than one fetch outstanding.
- R3: A clean decode result moves the read offset forward by one entry, modulo 2^cfgSizeLog2. Idle is high exactly when the block is not stalled, no fetch is outstanding, and the read offset equals the write offset.
- R4: A decode result with respErr=1 sets stalled on the next clock edge. The read offset stays on the faulting entry, and no rdReq is issued while stalled. Write-offset updates made while stalled are stored but cause no fetch.
- R5: With errRptEn=1, a fault sets errValid and loads errSyndrome from respSyndrome and errOffset from the faulting read offset. With errRptEn=0, the error record is left unchanged even though the queue still stalls.
- R6: A retry pulse while stalled clears stalled at the accepting edge and refetches the entry at the current read offset. A retry pulse while not stalled has no effect.
- R7: A write offset of 2^cfgSizeLog2 or more stalls the queue without issuing any fetch. With errRptEn=1, this records the syndrome value all-ones, with errOffset equal to the current read offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgBase | input | ADDR_W | Byte address of ring entry 0 |
| cfgSizeLog2 | input | SIZE_W | Ring holds 2^cfgSizeLog2 entries (1..MAX_LOG2) |
| errRptEn | input | 1 | Enables syndrome capture on faults |
| wrOffStb | input | 1 | Loads wrOffData into the write offset |
| wrOffData | input | MAX_LOG2 | New write offset in entries |
| retryStb | input | 1 | Resume request after a stall |
| rdReq | output | 1 | Fetch request, one cycle per entry |
| rdAddr | output | ADDR_W | Byte address of the requested entry |
| respValid | input | 1 | Decode result for the outstanding fetch |
| respErr | input | 1 | Decode result flags a faulty command |
| respSyndrome | input | SYN_W | Fault code from the decoder |
| rdOffset | output | MAX_LOG2 | Current read offset in entries |
| stalled | output | 1 | Queue stopped on a fault |
| idle | output | 1 | Queue drained |
| errValid | output | 1 | Error record holds a capture |
| errSyndrome | output | SYN_W | Captured fault code |
| errOffset | output | MAX_LOG2 | Read offset at the captured fault |

## Verification
The embedded properties check on every cycle that no fetch leaves while another is outstanding or while the queue is stalled, that a fault stalls the queue on the next edge, that the read offset is frozen while stalled, that an accepted retry drops the stall, and that no fetch is issued with an out-of-range write offset. Some behaviours only the bench scenarios can show. These are the ring order and the wrap of the fetch sequence, the exact count of fetches between two offsets, and the replay of the same entry after retry. They also include the record being left untouched when reporting is disabled, and the range fault that issues no fetch.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;
  localparam int ENTRY_LOG2 = 5;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_STALL
  } qstate_e;

  typedef struct packed {
    logic issue;
    logic advance;
    logic logCmd;
    logic logRange;
  } qstrobe_t;
endpackage

// File: rtl/cmdq_ctrl.sv
module cmdq_ctrl
  import cmdq_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     pending,
  input  logic     inRange,
  input  logic     retryStb,
  input  logic     respValid,
  input  logic     respErr,
  input  logic     errRptEn,
  output qstrobe_t stb,
  output logic     stalled,
  output logic     waiting
);
  qstate_e state, stateNext;

  always_comb begin
    stateNext = state;
    stb = '0;
    unique case (state)
      ST_IDLE: begin
        if (pending) begin
          if (!inRange) begin
            stateNext = ST_STALL;
            stb.logRange = errRptEn;
          end else begin
            stateNext = ST_WAIT;
            stb.issue = 1'b1;
          end
        end
      end
      ST_WAIT: begin
        if (respValid) begin
          if (respErr) begin
            stateNext = ST_STALL;
            stb.logCmd = errRptEn;
          end else begin
            stateNext = ST_IDLE;
            stb.advance = 1'b1;
          end
        end
      end
      ST_STALL: begin
        if (retryStb) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else state <= stateNext;
  end

  assign stalled = (state == ST_STALL);
  assign waiting = (state == ST_WAIT);

  // R2: a single fetch in flight
  a_r2_one_outstanding: assert property (@(posedge clk) disable iff (!rstN)
    waiting |-> !stb.issue);
  // R4: nothing fetched while stopped
  a_r4_no_issue_stalled: assert property (@(posedge clk) disable iff (!rstN)
    stalled |-> !stb.issue);
  // R4: a fault result stops the queue on the next edge
  a_r4_fault_stalls: assert property (@(posedge clk) disable iff (!rstN)
    (waiting && respValid && respErr) |=> stalled);
  // R6: an accepted retry drops the stall
  a_r6_retry_clears: assert property (@(posedge clk) disable iff (!rstN)
    (stalled && retryStb) |=> !stalled);
endmodule

// File: rtl/cmdq_dpath.sv
module cmdq_dpath
  import cmdq_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int MAX_LOG2 = 8,
  parameter int SYN_W    = 8,
  parameter int SIZE_W   = $clog2(MAX_LOG2 + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  qstrobe_t            stb,
  input  logic [ADDR_W-1:0]   cfgBase,
  input  logic [SIZE_W-1:0]   cfgSizeLog2,
  input  logic                wrOffStb,
  input  logic [MAX_LOG2-1:0] wrOffData,
  input  logic [SYN_W-1:0]    respSyndrome,
  output logic                pending,
  output logic                inRange,
  output logic [ADDR_W-1:0]   rdAddr,
  output logic [MAX_LOG2-1:0] rdOff,
  output logic [MAX_LOG2-1:0] wrOff,
  output logic                errValid,
  output logic [SYN_W-1:0]    errSyn,
  output logic [MAX_LOG2-1:0] errOff
);
  localparam int PAD_W = ADDR_W - MAX_LOG2 - ENTRY_LOG2;

  logic [MAX_LOG2:0]   entries;
  logic [MAX_LOG2-1:0] offMask;
  logic [MAX_LOG2-1:0] rdOffInc;

  assign entries  = {{MAX_LOG2{1'b0}}, 1'b1} << cfgSizeLog2;
  assign offMask  = entries[MAX_LOG2-1:0] - 1'b1;
  assign rdOffInc = (rdOff + 1'b1) & offMask;
  assign pending  = (rdOff != wrOff);
  assign inRange  = ({1'b0, wrOff} < entries);
  assign rdAddr   = cfgBase + {{PAD_W{1'b0}}, rdOff, {ENTRY_LOG2{1'b0}}};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdOff <= '0;
      wrOff <= '0;
    end else begin
      if (wrOffStb) wrOff <= wrOffData;
      if (stb.advance) rdOff <= rdOffInc;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      errValid <= 1'b0;
      errSyn   <= '0;
      errOff   <= '0;
    end else if (stb.logCmd || stb.logRange) begin
      errValid <= 1'b1;
      errSyn   <= stb.logRange ? {SYN_W{1'b1}} : respSyndrome;
      errOff   <= rdOff;
    end
  end

  // R3: the last entry of the ring steps back to entry 0
  a_r3_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (stb.advance && rdOff == offMask && !wrOffStb) |=> rdOff == '0);
endmodule

// File: rtl/cmdq_reader.sv
module cmdq_reader
  import cmdq_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int MAX_LOG2 = 8,
  parameter int SYN_W    = 8,
  parameter int SIZE_W   = $clog2(MAX_LOG2 + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   cfgBase,
  input  logic [SIZE_W-1:0]   cfgSizeLog2,
  input  logic                errRptEn,
  input  logic                wrOffStb,
  input  logic [MAX_LOG2-1:0] wrOffData,
  input  logic                retryStb,
  output logic                rdReq,
  output logic [ADDR_W-1:0]   rdAddr,
  input  logic                respValid,
  input  logic                respErr,
  input  logic [SYN_W-1:0]    respSyndrome,
  output logic [MAX_LOG2-1:0] rdOffset,
  output logic                stalled,
  output logic                idle,
  output logic                errValid,
  output logic [SYN_W-1:0]    errSyndrome,
  output logic [MAX_LOG2-1:0] errOffset
);
  qstrobe_t            stb;
  logic                pending, inRange, waiting;
  logic [MAX_LOG2-1:0] wrOff;

  cmdq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .pending(pending), .inRange(inRange),
    .retryStb(retryStb), .respValid(respValid), .respErr(respErr),
    .errRptEn(errRptEn), .stb(stb), .stalled(stalled), .waiting(waiting)
  );

  cmdq_dpath #(.ADDR_W(ADDR_W), .MAX_LOG2(MAX_LOG2), .SYN_W(SYN_W), .SIZE_W(SIZE_W)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .cfgBase(cfgBase), .cfgSizeLog2(cfgSizeLog2),
    .wrOffStb(wrOffStb), .wrOffData(wrOffData), .respSyndrome(respSyndrome),
    .pending(pending), .inRange(inRange), .rdAddr(rdAddr), .rdOff(rdOffset),
    .wrOff(wrOff), .errValid(errValid), .errSyn(errSyndrome), .errOff(errOffset)
  );

  assign rdReq = stb.issue;
  assign idle  = !stalled && !waiting && !pending;

  // R4: the read offset is frozen while stalled
  a_r4_offset_held: assert property (@(posedge clk) disable iff (!rstN)
    stalled |=> (!stalled || $stable(rdOffset)));
  // R7: fetches only go out with the write offset inside the ring
  a_r7_req_in_range: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |-> ({1'b0, wrOff} < ({{MAX_LOG2{1'b0}}, 1'b1} << cfgSizeLog2)));
endmodule

// File: tb/cmdq_reader_test.sv
module cmdq_reader_test;
  localparam int ADDR_W = 32;
  localparam int OFF_W  = 8;
  localparam int SYN_W  = 8;
  localparam int SIZE_W = 4;
  localparam logic [31:0] BASE = 32'h0001_0000;
  // table: write offset, expected read offset, expected fetch count
  localparam logic [7:0] TBL [5][3] = '{
    '{8'd3, 8'd3, 8'd3},
    '{8'd7, 8'd7, 8'd4},
    '{8'd2, 8'd2, 8'd3},
    '{8'd2, 8'd2, 8'd0},
    '{8'd1, 8'd1, 8'd7}
  };

  logic clk = 1'b0, rstN = 1'b0;
  logic [ADDR_W-1:0] cfgBase = BASE;
  logic [SIZE_W-1:0] cfgSizeLog2 = 4'd3;
  logic errRptEn = 1'b0, wrOffStb = 1'b0, retryStb = 1'b0;
  logic [OFF_W-1:0] wrOffData = '0;
  logic rdReq, stalled, idle, errValid;
  logic [ADDR_W-1:0] rdAddr;
  logic respValid = 1'b0, respErr = 1'b0;
  logic [SYN_W-1:0] respSyndrome = '0, errSyndrome;
  logic [OFF_W-1:0] rdOffset, errOffset;

  logic [7:0] badMask = '0;
  int readCount = 0;
  logic [31:0] lastAddr = '0;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  cmdq_reader uut (
    .clk(clk), .rstN(rstN), .cfgBase(cfgBase), .cfgSizeLog2(cfgSizeLog2),
    .errRptEn(errRptEn), .wrOffStb(wrOffStb), .wrOffData(wrOffData),
    .retryStb(retryStb), .rdReq(rdReq), .rdAddr(rdAddr), .respValid(respValid),
    .respErr(respErr), .respSyndrome(respSyndrome), .rdOffset(rdOffset),
    .stalled(stalled), .idle(idle), .errValid(errValid),
    .errSyndrome(errSyndrome), .errOffset(errOffset)
  );

  // command memory and decoder model: answers one cycle after each request
  initial begin
    forever begin
      @(posedge clk);
      if (rdReq) begin
        logic [2:0] ent;
        ent = 3'((rdAddr - BASE) >> 5);
        readCount++;
        lastAddr = rdAddr;
        respValid    <= 1'b1;
        respErr      <= badMask[ent];
        respSyndrome <= 8'h40 | {5'd0, ent};
      end else begin
        respValid <= 1'b0;
      end
    end
  end

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic writeOff(input logic [7:0] v);
    @(negedge clk);
    wrOffStb = 1'b1;
    wrOffData = v;
    @(negedge clk);
    wrOffStb = 1'b0;
  endtask

  task automatic retry();
    @(negedge clk);
    retryStb = 1'b1;
    @(negedge clk);
    retryStb = 1'b0;
  endtask

  task automatic settle();
    for (int i = 0; i < 200; i++) begin
      if (idle || stalled) break;
      @(negedge clk);
    end
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "rdOffset", 32'(rdOffset), 0);
    check("R1", "stalled", 32'(stalled), 0);
    check("R1", "idle", 32'(idle), 1);
    check("R1", "rdReq", 32'(rdReq), 0);
    check("R1", "errValid", 32'(errValid), 0);
    rstN = 1'b1;
    @(negedge clk);

    // R2 R3: table of offset moves, including wrap and no-op moves
    for (int v = 0; v < 5; v++) begin
      readCount = 0;
      writeOff(TBL[v][0]);
      settle();
      check("R3", "rdOffset", 32'(rdOffset), 32'(TBL[v][1]));
      check("R3", "idle", 32'(idle), 1);
      check("R2", "fetch count", readCount, 32'(TBL[v][2]));
      if (TBL[v][2] != 0)
        check("R2", "last address", lastAddr, BASE + 32'(((TBL[v][1] - 8'd1) & 8'd7)) * 32);
    end

    // R4 R5: fault at entry 4 with reporting on
    errRptEn = 1'b1;
    badMask = 8'h10;
    readCount = 0;
    writeOff(8'd6);
    settle();
    check("R4", "stalled", 32'(stalled), 1);
    check("R4", "rdOffset", 32'(rdOffset), 4);
    check("R4", "fetch count", readCount, 4);
    check("R4", "idle", 32'(idle), 0);
    check("R5", "errValid", 32'(errValid), 1);
    check("R5", "errSyndrome", 32'(errSyndrome), 32'h44);
    check("R5", "errOffset", 32'(errOffset), 4);

    // R4: write offset moves while stalled cause no fetch
    readCount = 0;
    writeOff(8'd7);
    repeat (10) @(negedge clk);
    check("R4", "fetch while stalled", readCount, 0);
    check("R4", "rdOffset held", 32'(rdOffset), 4);

    // R6: retry without repair replays the same entry
    readCount = 0;
    retry();
    check("R6", "stalled after retry", 32'(stalled), 0);
    settle();
    check("R6", "replay count", readCount, 1);
    check("R6", "replay address", lastAddr, BASE + 4 * 32);
    check("R6", "stalled again", 32'(stalled), 1);

    // R6: repaired entry lets the queue drain
    badMask = 8'h00;
    readCount = 0;
    retry();
    check("R6", "stalled after retry", 32'(stalled), 0);
    settle();
    check("R6", "rdOffset", 32'(rdOffset), 7);
    check("R6", "fetch count", readCount, 3);

    // R6: retry while not stalled is ignored
    readCount = 0;
    retry();
    repeat (5) @(negedge clk);
    check("R6", "ignored retry fetches", readCount, 0);
    check("R6", "ignored retry rdOffset", 32'(rdOffset), 7);
    check("R6", "ignored retry idle", 32'(idle), 1);

    // R5: reporting off leaves the record alone but still stalls
    errRptEn = 1'b0;
    badMask = 8'h01;
    readCount = 0;
    writeOff(8'd2);
    settle();
    check("R5", "stalled unreported", 32'(stalled), 1);
    check("R5", "rdOffset unreported", 32'(rdOffset), 0);
    check("R5", "errSyndrome kept", 32'(errSyndrome), 32'h44);
    check("R5", "errOffset kept", 32'(errOffset), 4);
    badMask = 8'h00;
    retry();
    settle();
    check("R3", "rdOffset after wrap fault", 32'(rdOffset), 2);

    // R7: write offset past the ring end
    errRptEn = 1'b1;
    readCount = 0;
    writeOff(8'd12);
    repeat (3) @(negedge clk);
    check("R7", "stalled", 32'(stalled), 1);
    check("R7", "fetch count", readCount, 0);
    check("R7", "errSyndrome", 32'(errSyndrome), 32'hFF);
    check("R7", "errOffset", 32'(errOffset), 2);
    writeOff(8'd5);
    retry();
    settle();
    check("R7", "rdOffset after fix", 32'(rdOffset), 5);
    check("R7", "fetch count after fix", readCount, 3);
    check("R7", "idle after fix", 32'(idle), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule